// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block places received Ethernet frames into memory buffers that software describes with descriptors. Each descriptor is four 32-bit words at a word-aligned byte address. Word 0 carries the ownership flag and, after reception, the status. The low bits of word 1 hold the buffer size. Word 2 holds the buffer address and word 3 holds the address of the next descriptor. Frames arrive one byte per cycle on a stream that marks the first and last byte. On the last byte the stream also reports a CRC error and an alignment error.

The engine reads the whole descriptor ahead of time. It then packs the incoming bytes into 32-bit words and writes them into the buffer. After the last byte it decides whether the frame passes the destination filter. If it passes, the engine writes the status word, gives the descriptor back to software and follows the chain pointer to the next descriptor. Two descriptors that point at each other form a ring. When the engine finds a descriptor that software still holds, it re-reads it at a fixed interval. A frame that starts while no descriptor is ready is dropped and counted.

Memory is reached through one port. A read returns its data one cycle after the read strobe is seen by memory, so `mem_rdata` is valid two cycles after the engine raises `mem_re`.

Top module: `rxdesc_wb`

## Requirements
- R1: Reset behaviour.
  - While reset is held, no memory write occurs and `miss_count` is zero.
  - The first memory read after reset is word 0 of the descriptor at `ring_base`.
- R2: Ownership (word 0 bit 31 = 1 means owned by hardware).
  - A frame that arrives while the current descriptor is not owned by hardware is dropped. `miss_count` increments and the descriptor is left unwritten.
  - Once software sets the bit again, the engine picks the descriptor up by periodic re-reading, and a later frame is stored there.
- R3: Buffer packing.
  - Frame byte n goes to buffer byte address (word 2) + n, packed little-endian (byte n in bits 8*(n mod 4)+7 : 8*(n mod 4)).
  - The unused upper bytes of a final partial word are written as zero.
- R4: Status write-back of an accepted frame.
  - The status word is written into word 0 with bit 31 cleared.
  - Bits 30:16 hold the total number of received bytes, including the 4-byte FCS, saturating at 32767.
  - Bit 9 (first segment) and bit 8 (last segment) are set. Bit 10 (continues) and bit 3 are zero.
- R5: Destination class, taken from the first six bytes of the frame.
  - Bit 12 is set for the all-ones address.
  - Bit 13 is set for any other address whose first byte has bit 0 set.
  - Bit 11 is set otherwise.
- R6: Destination filter.
  - `flt_promisc` accepts every frame.
  - A broadcast frame is accepted when `flt_bcast` is high.
  - A unicast frame is accepted when its destination equals `sta_addr` (first byte in bits 7:0).
  - A multicast frame is accepted only in promiscuous mode.
  - For a rejected frame, word 0 stays unchanged and the next frame uses the same descriptor.
- R7: Buffer size.
  - The buffer size in bytes is word 1 bits 14:2 times four.
  - Bytes beyond the buffer are not written.
  - Such a frame sets bit 4 (too long), bit 0 (error summary) and clears bit 15 (good).
- R8: A frame shorter than 64 bytes (FCS included) sets bit 5 (runt) and bit 0, and clears bit 15.
- R9: Error reporting.
  - A CRC error flag sets bit 1 and an alignment error flag sets bit 2. Either one sets bit 0 and clears bit 15.
  - An error-free frame of 64 bytes or more has bit 15 set and bits 5:0 zero.
- R10: After writing the status, the engine moves to the descriptor whose address is in word 3, so a two-entry ring alternates.
- R11: A frame whose first byte arrives while the engine is writing back or fetching is dropped and counted in `miss_count`. Its later bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Address of the first descriptor, loaded during reset |
| sta_addr | input | 48 | Station address, first byte in bits 7:0 |
| flt_promisc | input | 1 | Accept every frame |
| flt_bcast | input | 1 | Accept broadcast frames |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC error, sampled with the last byte |
| in_align_err | input | 1 | Alignment error, sampled with the last byte |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| miss_count | output | CNT_W | Dropped-frame count |

## Verification
A table drives unicast, broadcast and multicast destinations through every combination of the promiscuous and broadcast filter settings. This separates filter acceptance from class marking, because a rejected frame must leave word 0 owned and must not advance the ring. The same table varies frame length and error flags:
- lengths 63, 64 and 65 sit on either side of the runt threshold;
- lengths that are not a multiple of four expose the zero padding of the last word;
- lone CRC and alignment errors show that each reaches its own bit.

Directed runs cover further cases:
- A frame larger than the buffer, to check that the limit holds.
- A descriptor that software still holds, which tells a drop from a late pickup.
- A frame that starts directly after another, which lands in the write-back window and must be counted as missed.

// File: rtl/rxdesc_wb.sv
module rxdesc_wb #(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64,
  parameter int CNT_W     = 16,
  parameter int POLL_GAP  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    ring_base,
  input  logic [47:0]      sta_addr,
  input  logic             flt_promisc,
  input  logic             flt_bcast,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_err,
  input  logic             in_align_err,
  output logic             mem_re,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [CNT_W-1:0] miss_count
);
  localparam int PW = $clog2(POLL_GAP) + 1;

  typedef enum logic [2:0] {S_FETCH, S_READY, S_RECV, S_WB, S_STALL} st_t;

  st_t           st;
  logic [AW-1:0] cur, nxt, buf_addr;
  logic [15:0]   buf_len, cnt;
  logic          own_q, crc_q, al_q, long_q;
  logic [2:0]    fcnt;
  logic [PW-1:0] pcnt;
  logic [31:0]   wacc;
  logic [47:0]   da;

  wire        take   = in_valid && ((st == S_READY && in_sof) || st == S_RECV);
  wire [15:0] pos    = (st == S_RECV) ? cnt : 16'd0;
  wire [1:0]  lane   = pos[1:0];
  wire        in_buf = pos < buf_len;
  wire [31:0] wnext  = ((lane == 2'd0) ? 32'd0 : wacc) | (32'(in_data) << {lane, 3'b000});

  wire bcast  = &da;
  wire mcast  = da[0] & ~bcast;
  wire ucast  = ~da[0];
  wire accept = flt_promisc | (bcast & flt_bcast) | (ucast & (da == sta_addr));

  wire        runt = cnt < 16'(MIN_FRAME);
  wire        err  = crc_q | al_q | long_q | runt;
  wire [14:0] flen = cnt[15] ? 15'h7fff : cnt[14:0];
  wire [31:0] stat = {1'b0, flen, ~err, 1'b0, mcast, bcast, ucast, 1'b0, 1'b1, 1'b1,
                      2'b00, runt, long_q, 1'b0, al_q, crc_q, err};

  wire sof_miss = in_valid && in_sof && st != S_READY && st != S_RECV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_FETCH;
      cur        <= ring_base;
      nxt        <= '0;
      buf_addr   <= '0;
      buf_len    <= '0;
      cnt        <= '0;
      own_q      <= 1'b0;
      crc_q      <= 1'b0;
      al_q       <= 1'b0;
      long_q     <= 1'b0;
      fcnt       <= '0;
      pcnt       <= '0;
      wacc       <= '0;
      da         <= '0;
      mem_re     <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      miss_count <= '0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      if (sof_miss) miss_count <= miss_count + 1'b1;

      if (take) begin
        if (in_buf) begin
          wacc <= wnext;
          if (lane == 2'd3 || in_eof) begin
            mem_we    <= 1'b1;
            mem_addr  <= buf_addr + AW'({pos[15:2], 2'b00});
            mem_wdata <= wnext;
          end
        end
        long_q <= ((st == S_READY) ? 1'b0 : long_q) | ~in_buf;
        if (st == S_READY) da <= {40'd0, in_data};
        else if (pos < 16'd6) da[{pos[2:0], 3'b000} +: 8] <= in_data;
        cnt <= (&pos) ? pos : pos + 16'd1;
        if (in_eof) begin
          crc_q <= in_crc_err;
          al_q  <= in_align_err;
          st    <= S_WB;
        end else begin
          st <= S_RECV;
        end
      end

      case (st)
        S_FETCH: begin
          fcnt <= fcnt + 3'd1;
          if (fcnt < 3'd4) begin
            mem_re   <= 1'b1;
            mem_addr <= cur + AW'({fcnt[1:0], 2'b00});
          end
          case (fcnt)
            3'd2: own_q    <= mem_rdata[31];
            3'd3: buf_len  <= {1'b0, mem_rdata[14:2], 2'b00};
            3'd4: buf_addr <= mem_rdata[AW-1:0];
            3'd5: begin
              nxt  <= mem_rdata[AW-1:0];
              fcnt <= '0;
              pcnt <= '0;
              st   <= own_q ? S_READY : S_STALL;
            end
            default: ;
          endcase
        end
        S_WB: begin
          if (accept) begin
            mem_we    <= 1'b1;
            mem_addr  <= cur;
            mem_wdata <= stat;
            cur       <= nxt;
            st        <= S_FETCH;
          end else begin
            st <= S_READY;
          end
        end
        S_STALL: begin
          if (pcnt == PW'(POLL_GAP - 1)) st <= S_FETCH;
          else pcnt <= pcnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r4_status_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && accept) |=> (mem_we && !mem_wdata[31] && mem_addr == $past(cur)));

  a_r10_follow_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && accept) |=> (cur == $past(nxt) && st == S_FETCH));

  a_r2_stall_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STALL) |=> !mem_we);

  a_r11_busy_sof_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && (st == S_WB || st == S_FETCH)) |=> (miss_count == $past(miss_count) + 1'b1));

  a_r6_reject_keeps_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WB && !accept) |=> (!mem_we && cur == $past(cur)));

  always_ff @(posedge clk) begin
    if (rst_n) a_r3_single_access: assert (!(mem_we && mem_re));
  end
endmodule

// File: tb/rxdesc_wb_test.sv
`timescale 1ns/1ps
module rxdesc_wb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h10;
  logic [47:0] sta_addr = 48'h55_44_33_22_11_02;
  logic        flt_promisc = 1'b0, flt_bcast = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic        in_crc_err = 1'b0, in_align_err = 1'b0;
  logic [7:0]  in_data = 8'd0;
  logic        mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] miss_count;

  always #10 clk = ~clk;

  rxdesc_wb uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .sta_addr(sta_addr),
    .flt_promisc(flt_promisc), .flt_bcast(flt_bcast),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err), .in_align_err(in_align_err),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .miss_count(miss_count));

  logic [31:0] mem [0:255];
  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr[9:2]];
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  int checks = 0, fails = 0;
  bit done = 0, seen_rd = 0, rst_wr = 0;
  logic [31:0] first_rd;
  int cur_d, exp_miss = 0;

  always @(posedge clk) begin
    if (!rst_n && mem_we) rst_wr = 1;
    if (rst_n && mem_re && !seen_rd) begin seen_rd = 1; first_rd = mem_addr; end
  end

  typedef struct packed {
    logic [47:0] da; logic [15:0] len;
    logic crc, al, prom, bc, acc;
    logic [31:0] stat;
  } vec_t;

  localparam logic [47:0] STA = 48'h55_44_33_22_11_02;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h00_00_00_5E_00_01;
  localparam logic [47:0] OTH = 48'h55_44_33_22_11_04;

  localparam vec_t VT [0:10] = '{
    '{STA, 16'd64,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0040_8B00},
    '{BC,  16'd100, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0064_9300},
    '{BC,  16'd64,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000},
    '{MC,  16'd70,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0046_A300},
    '{MC,  16'd64,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h8000_0000},
    '{OTH, 16'd64,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h8000_0000},
    '{OTH, 16'd65,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0041_8B00},
    '{STA, 16'd64,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0040_0B03},
    '{STA, 16'd80,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0050_0B05},
    '{STA, 16'd40,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0028_0B21},
    '{STA, 16'd63,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h003F_0B21}
  };

  function automatic logic [7:0] fb(input logic [47:0] da, input int i, input int seed);
    if (i < 6) return da[8*i +: 8];
    return 8'((seed * 13 + i * 7) & 255);
  endfunction

  function automatic int buf_of(input int d);
    return (d == 0) ? 32'h100 : 32'h200;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [47:0] da, input int len, input bit crc, input bit al, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = fb(da, i, seed);
      in_sof = (i == 0); in_eof = (i == len - 1);
      in_crc_err = (i == len - 1) && crc; in_align_err = (i == len - 1) && al;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_crc_err = 1'b0; in_align_err = 1'b0;
  endtask

  task automatic fill_buf(input int d);
    for (int w = 0; w < 32; w++) mem[(buf_of(d) >> 2) + w] = 32'hDEAD_BEEF;
  endtask

  task automatic chk_buf(input string req, input int d, input logic [47:0] da, input int len, input int seed, input int stored);
    logic [31:0] bad_a, bad_e;
    bit ok;
    ok = 1; bad_a = 0; bad_e = 0;
    for (int w = 0; w < (stored + 3) / 4; w++) begin
      logic [31:0] e;
      e = 32'd0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < stored && 4 * w + b < len) e[8*b +: 8] = fb(da, 4 * w + b, seed);
      if (ok && mem[(buf_of(d) >> 2) + w] !== e) begin
        ok = 0; bad_a = mem[(buf_of(d) >> 2) + w]; bad_e = e;
      end
    end
    chk(ok, req, bad_a, bad_e);
  endtask

  task automatic rearm(input int d);
    mem[d >> 2] = 32'h8000_0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    mem[0] = 32'h8000_0000; mem[1] = 32'd128; mem[2] = 32'h100; mem[3] = 32'h10;
    mem[4] = 32'h8000_0000; mem[5] = 32'd128; mem[6] = 32'h200; mem[7] = 32'h00;
    cur_d = 32'h10;
    cyc(5);
    chk(miss_count == 16'd0, "R1 miss_count in reset", 32'(miss_count), 0);
    chk(!rst_wr, "R1 no write in reset", 32'(rst_wr), 0);
    rst_n = 1'b1;
    cyc(30);
    chk(seen_rd && first_rd == 32'h10, "R1 first read at ring_base", first_rd, 32'h10);

    for (int k = 0; k < 11; k++) begin
      vec_t v;
      v = VT[k];
      flt_promisc = v.prom; flt_bcast = v.bc;
      fill_buf(cur_d == 0 ? 0 : 1);
      send(v.da, int'(v.len), v.crc, v.al, k);
      cyc(30);
      chk(mem[cur_d >> 2] == v.stat, $sformatf("R4/R5/R6/R8/R9/R10 row %0d status", k), mem[cur_d >> 2], v.stat);
      chk(miss_count == 16'(exp_miss), $sformatf("R11 row %0d no miss", k), 32'(miss_count), exp_miss);
      if (v.acc) begin
        chk_buf($sformatf("R3 row %0d buffer", k), cur_d == 0 ? 0 : 1, v.da, int'(v.len), k, int'(v.len));
        rearm(cur_d);
        cur_d ^= 32'h10;
      end
      cyc(30);
    end
    flt_promisc = 1'b0; flt_bcast = 1'b0;

    // R11: back-to-back frame lands in the write-back window
    send(STA, 64, 0, 0, 50);
    send(STA, 64, 0, 0, 51);
    exp_miss++;
    cyc(40);
    chk(mem[cur_d >> 2] == 32'h0040_8B00, "R11 first frame stored", mem[cur_d >> 2], 32'h0040_8B00);
    chk(miss_count == 16'(exp_miss), "R11 busy frame counted", 32'(miss_count), exp_miss);
    chk(mem[(cur_d ^ 32'h10) >> 2] == 32'h8000_0000, "R11 next descriptor untouched",
        mem[(cur_d ^ 32'h10) >> 2], 32'h8000_0000);
    rearm(cur_d); cur_d ^= 32'h10;
    cyc(30);

    // R2: next descriptor still held by software
    mem[(cur_d ^ 32'h10) >> 2] = 32'd0;
    send(STA, 64, 0, 0, 60);
    cyc(30);
    chk(mem[cur_d >> 2] == 32'h0040_8B00, "R2 frame before stall", mem[cur_d >> 2], 32'h0040_8B00);
    rearm(cur_d); cur_d ^= 32'h10;
    cyc(30);
    send(STA, 64, 0, 0, 61);
    exp_miss++;
    cyc(30);
    chk(miss_count == 16'(exp_miss), "R2 dropped frame counted", 32'(miss_count), exp_miss);
    chk(mem[cur_d >> 2] == 32'd0, "R2 unowned descriptor untouched", mem[cur_d >> 2], 0);
    rearm(cur_d);
    cyc(60);
    fill_buf(cur_d == 0 ? 0 : 1);
    send(STA, 68, 0, 0, 62);
    cyc(30);
    chk(mem[cur_d >> 2] == 32'h0044_8B00, "R2 picked up after re-arm", mem[cur_d >> 2], 32'h0044_8B00);
    chk(miss_count == 16'(exp_miss), "R2 no extra miss", 32'(miss_count), exp_miss);
    rearm(cur_d); cur_d ^= 32'h10;
    cyc(30);

    // R7: buffer smaller than the frame
    mem[((cur_d ^ 32'h10) >> 2) + 1] = 32'h43;
    send(STA, 64, 0, 0, 70);
    cyc(30);
    chk(mem[cur_d >> 2] == 32'h0040_8B00, "R10 frame before long", mem[cur_d >> 2], 32'h0040_8B00);
    rearm(cur_d); cur_d ^= 32'h10;
    fill_buf(cur_d == 0 ? 0 : 1);
    cyc(30);
    send(STA, 72, 0, 0, 71);
    cyc(30);
    chk(mem[cur_d >> 2] == 32'h0048_0B11, "R7 long status", mem[cur_d >> 2], 32'h0048_0B11);
    chk_buf("R7 stored part", cur_d == 0 ? 0 : 1, STA, 72, 71, 64);
    chk(mem[(buf_of(cur_d == 0 ? 0 : 1) >> 2) + 16] == 32'hDEAD_BEEF, "R7 nothing past buffer",
        mem[(buf_of(cur_d == 0 ? 0 : 1) >> 2) + 16], 32'hDEAD_BEEF);
    mem[(cur_d >> 2) + 1] = 32'd128;
    rearm(cur_d);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule